// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block takes configuration words from a three-wire serial link: a data line, a serial clock and a load strobe. On each rising serial clock edge, one data bit enters a shift register. The most significant bit comes first, so the last bit sent sits at the lowest position. When the load strobe rises, the two lowest bits of the captured word pick one of four holding registers. Those registers are a reference-divider setting and a main/swallow-divider setting for each of two channels. The word is copied into the chosen register.

All three serial inputs pass through a synchronizer into the system clock domain. Edges are found there, so no logic runs on the serial clock itself. Each holding register drives its decoded fields on the ports. It also raises a one-cycle update strobe in the cycle its new contents appear, so the divider counters downstream know when to pick them up.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, every decoded field output is zero and all four update strobes are low.
- R2: Each rising edge of the serial clock shifts in one data bit. Bits are sent most significant first, so after a 23-bit frame the last bit sent is frame bit 1, the lowest position.
- R3: On a rising edge of the load strobe, frame bits 1 and 2 select the destination. Bit 1 gives the channel (0 = channel 0, 1 = channel 1). Bit 2 gives the kind (0 = reference setting, 1 = main/swallow setting).
- R4: In a reference frame, bits 3 and 4 are the test field (bit 3 is its LSB). Bits 5 to 18 are the 14-bit reference ratio (bit 5 is its LSB). Bit 19 is the charge-pump select.
- R5: In a main/swallow frame, bits 3 to 9 are the 7-bit swallow count (bit 3 is its LSB). Bits 10 to 20 are the 11-bit main count (bit 10 is its LSB).
- R6: A load changes only the selected register. The other three keep their field outputs.
- R7: Each load raises exactly the selected register's update strobe for exactly one system clock cycle, in the first cycle its new fields are visible.
- R8: Frame bits 20 to 23 of a reference frame and bits 21 to 23 of a main/swallow frame have no effect on any output, whatever their value.
- R9: Shifting bits without a load-strobe rising edge changes no output and raises no strobe. A load strobe held high produces a single load.
- R10: When more than 23 bits are shifted before a load, only the last 23 bits count. Earlier bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat_i | input | 1 | Serial data line |
| ser_sck_i | input | 1 | Serial clock line, sampled in the system domain |
| ser_ld_i | input | 1 | Load strobe line, rising edge loads |
| ref_ratio_o | output | 2x14 | Reference ratio per channel |
| ref_cp_sel_o | output | 2 | Charge-pump select per channel |
| ref_test_o | output | 2x2 | Test field per channel |
| ref_upd_o | output | 2 | Reference register update strobe per channel |
| div_main_o | output | 2x11 | Main count per channel |
| div_swal_o | output | 2x7 | Swallow count per channel |
| div_upd_o | output | 2 | Main/swallow register update strobe per channel |

## Verification
The assertions assume that the serial clock and the load strobe each stay at a level for more than the synchronizer depth. They assume that the data line is steady for a few system cycles on both sides of every serial clock rise. They also assume that a serial clock rise and a load rise never fall in the same system cycle. Under those assumptions, each detected load rise maps to exactly one strobe. The stimulus holds every line level for at least three system cycles. It changes data only three cycles after the serial clock falls and raises the load strobe only after the serial clock has settled low.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   // width of the destination selector at the bottom of every frame
   localparam int CTL_W = 2;

   // selector code: upper bit picks the register kind, lower bit the channel
   function automatic logic [CTL_W-1:0] dest_code(input logic kind_div, input logic chan);
      return {kind_div, chan};
   endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_i,
   output logic [W-1:0] out_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], in_i};
   end

   assign out_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);
   if (W < 2) begin : g_bad_width
      $error("cfg_shreg: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_o <= '0;
      else if (step_i) word_o <= {word_o[W-2:0], bit_i};
   end
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         upd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= '0;
         upd_o <= 1'b0;
      end else begin
         upd_o <= ld_i;
         if (ld_i) q_o <= d_i;
      end
   end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
   import cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_W     = 23,
   parameter int TEST_W      = 2,
   parameter int REF_W       = 14,
   parameter int SWAL_W      = 7,
   parameter int MAIN_W      = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ser_dat_i,
   input  logic                          ser_sck_i,
   input  logic                          ser_ld_i,
   output logic [1:0][REF_W-1:0]         ref_ratio_o,
   output logic [1:0]                    ref_cp_sel_o,
   output logic [1:0][TEST_W-1:0]        ref_test_o,
   output logic [1:0]                    ref_upd_o,
   output logic [1:0][MAIN_W-1:0]        div_main_o,
   output logic [1:0][SWAL_W-1:0]        div_swal_o,
   output logic [1:0]                    div_upd_o
);
   // reference frame payload: test, ratio, charge-pump select
   localparam int REF_END = CTL_W + TEST_W + REF_W + 1;
   localparam int REF_PW  = REF_END - CTL_W;
   // main/swallow frame payload: swallow then main
   localparam int DIV_END = CTL_W + SWAL_W + MAIN_W;
   localparam int DIV_PW  = DIV_END - CTL_W;
   // bits above the highest decoded field are never read, so they are not stored
   localparam int KEEP_W  = (REF_END > DIV_END) ? REF_END : DIV_END;

   if (KEEP_W > FRAME_W) begin : g_bad_frame
      $error("serial_cfg_loader: fields exceed FRAME_W");
   end

   // ---------------- input synchronization and edge detection
   logic [2:0] lines_s;
   logic [1:0] prev_q;
   logic       sck_rise, ld_rise;

   cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  ({ser_ld_i, ser_sck_i, ser_dat_i}),
      .out_o (lines_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines_s[2:1];
   end

   assign sck_rise = lines_s[1] & ~prev_q[0];
   assign ld_rise  = lines_s[2] & ~prev_q[1];

   // ---------------- shift register
   logic [KEEP_W-1:0] sh_q;

   cfg_shreg #(.W(KEEP_W)) u_shreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (sck_rise),
      .bit_i  (lines_s[0]),
      .word_o (sh_q)
   );

   // ---------------- per-channel destination registers
   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic              ref_ld, div_ld;
      logic [REF_PW-1:0] ref_q;
      logic [DIV_PW-1:0] div_q;

      assign ref_ld = ld_rise && (sh_q[CTL_W-1:0] == dest_code(1'b0, 1'(ch)));
      assign div_ld = ld_rise && (sh_q[CTL_W-1:0] == dest_code(1'b1, 1'(ch)));

      cfg_hold #(.W(REF_PW)) u_ref (
         .clk   (clk),
         .rst_n (rst_n),
         .ld_i  (ref_ld),
         .d_i   (sh_q[REF_END-1:CTL_W]),
         .q_o   (ref_q),
         .upd_o (ref_upd_o[ch])
      );

      cfg_hold #(.W(DIV_PW)) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .ld_i  (div_ld),
         .d_i   (sh_q[DIV_END-1:CTL_W]),
         .q_o   (div_q),
         .upd_o (div_upd_o[ch])
      );

      assign ref_test_o[ch]   = ref_q[TEST_W-1:0];
      assign ref_ratio_o[ch]  = ref_q[TEST_W +: REF_W];
      assign ref_cp_sel_o[ch] = ref_q[TEST_W + REF_W];
      assign div_swal_o[ch]   = div_q[SWAL_W-1:0];
      assign div_main_o[ch]   = div_q[SWAL_W +: MAIN_W];
   end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int REF_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_rise,
   input logic [1:0]       sel,
   input logic [3:0]       upd,
   input logic [REF_W-1:0] ratio0
);
   // R7
   upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd));

   // R9
   no_load_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> (upd == 4'b0000));

   // R3
   dest_ref0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && sel == 2'b00) |=> (upd == 4'b0001));

   // R3
   dest_div1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && sel == 2'b11) |=> (upd == 4'b1000));

   // R6
   ref0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd[0] |-> $stable(ratio0));
endmodule

bind serial_cfg_loader cfg_loader_chk #(.REF_W(REF_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_rise (ld_rise),
   .sel     (sh_q[1:0]),
   .upd     ({div_upd_o, ref_upd_o}),
   .ratio0  (ref_ratio_o[0])
);

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_dat = 1'b0, ser_sck = 1'b0, ser_ld = 1'b0;
   logic [1:0][13:0] ref_ratio;
   logic [1:0]       ref_cp;
   logic [1:0][1:0]  ref_test;
   logic [1:0]       ref_upd;
   logic [1:0][10:0] div_main;
   logic [1:0][6:0]  div_swal;
   logic [1:0]       div_upd;

   int checks = 0, errors = 0;
   int n_upd [4];
   int base  [4];

   // expected register contents
   logic [13:0] e_ratio [2];
   logic        e_cp    [2];
   logic [1:0]  e_test  [2];
   logic [10:0] e_main  [2];
   logic [6:0]  e_swal  [2];

   always #2.5 clk = ~clk;

   serial_cfg_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_dat_i(ser_dat), .ser_sck_i(ser_sck), .ser_ld_i(ser_ld),
      .ref_ratio_o(ref_ratio), .ref_cp_sel_o(ref_cp), .ref_test_o(ref_test), .ref_upd_o(ref_upd),
      .div_main_o(div_main), .div_swal_o(div_swal), .div_upd_o(div_upd)
   );

   // strobe-cycle counters, index: 0 ref ch0, 1 ref ch1, 2 div ch0, 3 div ch1
   always @(negedge clk) begin
      if (ref_upd[0]) n_upd[0]++;
      if (ref_upd[1]) n_upd[1]++;
      if (div_upd[0]) n_upd[2]++;
      if (div_upd[1]) n_upd[3]++;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < 2; c++) begin
         check({tag, " ratio"}, 32'(ref_ratio[c]), 32'(e_ratio[c]));
         check({tag, " cp"},    32'(ref_cp[c]),    32'(e_cp[c]));
         check({tag, " test"},  32'(ref_test[c]),  32'(e_test[c]));
         check({tag, " main"},  32'(div_main[c]),  32'(e_main[c]));
         check({tag, " swal"},  32'(div_swal[c]),  32'(e_swal[c]));
      end
   endtask

   // expected strobe cycles since last call, {div1,div0,ref1,ref0}
   task automatic check_upd(input string tag, input logic [3:0] exp);
      for (int k = 0; k < 4; k++) begin
         check({tag, " strobe"}, 32'(n_upd[k] - base[k]), 32'(exp[k]));
         base[k] = n_upd[k];
      end
   endtask

   task automatic shift_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = v[i];
         repeat (3) @(negedge clk);
         ser_sck = 1'b1;
         repeat (4) @(negedge clk);
         ser_sck = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic pulse_load(input int hold);
      ser_ld = 1'b1;
      repeat (hold) @(negedge clk);
      ser_ld = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [22:0] ref_frame(input logic ch, input logic [13:0] r,
                                             input logic cp, input logic [1:0] t, input logic [3:0] dc);
      return {dc, cp, r, t, 1'b0, ch};
   endfunction

   function automatic logic [22:0] div_frame(input logic ch, input logic [10:0] m,
                                             input logic [6:0] s, input logic [2:0] dc);
      return {dc, m, s, 1'b1, ch};
   endfunction

   task automatic t_reset;
      for (int c = 0; c < 2; c++) begin
         e_ratio[c] = '0; e_cp[c] = 1'b0; e_test[c] = '0; e_main[c] = '0; e_swal[c] = '0;
      end
      check_all("R1 reset");
      check_upd("R1 reset", 4'b0000);
   endtask

   task automatic t_ref_frames;
      // asymmetric ratio catches bit order (R2) and field placement (R4)
      shift_bits(32'(ref_frame(1'b0, 14'h2A5C, 1'b1, 2'b10, 4'h0)), 23);
      pulse_load(4);
      e_ratio[0] = 14'h2A5C; e_cp[0] = 1'b1; e_test[0] = 2'b10;
      check_all("R2 R4 ref ch0");
      check_upd("R3 R7 ref ch0", 4'b0001);
      shift_bits(32'(ref_frame(1'b1, 14'd16383, 1'b0, 2'b01, 4'h0)), 23);
      pulse_load(4);
      e_ratio[1] = 14'd16383; e_test[1] = 2'b01;
      check_all("R6 ref ch1");
      check_upd("R3 R7 ref ch1", 4'b0010);
      shift_bits(32'(ref_frame(1'b1, 14'd3, 1'b1, 2'b00, 4'h0)), 23);
      pulse_load(4);
      e_ratio[1] = 14'd3; e_cp[1] = 1'b1; e_test[1] = 2'b00;
      check_all("R4 ref ch1 min ratio");
      check_upd("R7 ref ch1 reload", 4'b0010);
   endtask

   task automatic t_div_frames;
      shift_bits(32'(div_frame(1'b0, 11'd2047, 7'd0, 3'b000)), 23);
      pulse_load(4);
      e_main[0] = 11'd2047; e_swal[0] = 7'd0;
      check_all("R5 div ch0");
      check_upd("R3 R7 div ch0", 4'b0100);
      shift_bits(32'(div_frame(1'b1, 11'h4A3, 7'h55, 3'b000)), 23);
      pulse_load(4);
      e_main[1] = 11'h4A3; e_swal[1] = 7'h55;
      check_all("R5 R6 div ch1");
      check_upd("R3 R7 div ch1", 4'b1000);
   endtask

   task automatic t_dont_care;
      shift_bits(32'(ref_frame(1'b1, 14'd3, 1'b1, 2'b00, 4'hF)), 23);
      pulse_load(4);
      check_all("R8 ref dont-care");
      check_upd("R8 ref dont-care", 4'b0010);
      shift_bits(32'(div_frame(1'b1, 11'h4A3, 7'h55, 3'b111)), 23);
      pulse_load(4);
      check_all("R8 div dont-care");
      check_upd("R8 div dont-care", 4'b1000);
   endtask

   task automatic t_no_load;
      shift_bits(32'(ref_frame(1'b0, 14'h1111, 1'b0, 2'b11, 4'h0)), 23);
      repeat (10) @(negedge clk);
      check_all("R9 shift without load");
      check_upd("R9 shift without load", 4'b0000);
      // held-high load: one load only
      shift_bits(32'(div_frame(1'b0, 11'h123, 7'h3C, 3'b000)), 23);
      pulse_load(60);
      e_main[0] = 11'h123; e_swal[0] = 7'h3C;
      check_all("R9 long load");
      check_upd("R9 long load", 4'b0100);
   endtask

   task automatic t_overlong;
      // 5 leading junk bits, then a full reference frame
      shift_bits({4'h0, 5'b10110, ref_frame(1'b0, 14'h0F0F, 1'b0, 2'b01, 4'h0)}, 28);
      pulse_load(4);
      e_ratio[0] = 14'h0F0F; e_cp[0] = 1'b0; e_test[0] = 2'b01;
      check_all("R10 overlong frame");
      check_upd("R10 overlong frame", 4'b0001);
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin n_upd[k] = 0; base[k] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      t_reset();
      t_ref_frames();
      t_div_frames();
      t_dont_care();
      t_no_load();
      t_overlong();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule